// File: doc/BRIEF.md
# Multiplier-resolution watchdog timer

This block watches a processor for signs of life. Software loads one 8-bit control register. The register holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout period is the multiplier times the time step that the resolution code selects. A 16 Hz tick enable advances the count; it is derived elsewhere from the 32.768 kHz time base.

Every access to the control register restarts the period, whether the access is a read or a write. If the period runs out before the next access, the block sets a sticky watchdog flag. When the steering bit is clear, it also raises an interrupt request. Both stay set until software reads the flags register or accesses the control register again.

A register value with a zero multiplier disables the watchdog, and power-up reset leaves the register at 00h. Physical pin behaviour, such as open-drain drive, belongs to the pad ring and is not part of this block.

Top module: `wdog_mulres`

## Requirements
- R1: After reset the control register reads 00h and both the flag and the interrupt request are low.
- R2: A register access with the write qualifier high loads reg_wdata into the register. The new value shows on ctl_q one cycle later. An access with the qualifier low leaves ctl_q unchanged.
- R3: The register fields are: bit 7 = steering bit, bits 6:2 = multiplier M, bits 1:0 = resolution code C. The timeout is M × 4^C ticks, so codes 0, 1, 2 and 3 select 1, 4, 16 and 64 ticks per step (1/16 s, 1/4 s, 1 s and 4 s). The flag rises on the tick that completes the timeout, counted from the last register access.
- R4: Any register access, read or write, restarts the count from zero.
- R5: On expiry the flag goes high. If the steering bit is 0, the interrupt request also goes high.
- R6: If the steering bit is 1, expiry sets the flag but the interrupt request stays low.
- R7: The flags-read strobe clears both the flag and the interrupt request, and so does a register access.
- R8: When the multiplier is zero the watchdog is disabled. The flag never rises, whatever the resolution code and however many ticks arrive.
- R9: After an expiry the count restarts, so the next expiry follows a full period later. If expiry and a flags-read strobe fall in the same cycle, the flag is still set.
- R10: A tick that arrives in the same cycle as a register access does not count. The period starts from zero after that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| tick | input | 1 | One-cycle enable at 16 Hz |
| reg_acc | input | 1 | Control register access strobe (read or write) |
| reg_wr | input | 1 | Write qualifier for reg_acc |
| reg_wdata | input | 8 | Write data for the control register |
| flag_rd | input | 1 | Flags register read strobe |
| ctl_q | output | 8 | Current control register value |
| wd_flag | output | 1 | Sticky watchdog expiry flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default widths: a 5-bit multiplier, a 2-bit resolution code and a ratio of four between steps. It sweeps every multiplier from 1 to 31 at the two finest resolutions, and chosen multipliers at the two coarsest, including 64-tick steps. Each case checks that the flag is still low one tick before the computed timeout M × 4^C and high on exactly that tick. Because the periods stay short, the restart, disable, steering and same-cycle priority cases can all be checked at the exact tick where they matter.

// File: rtl/wdog_mulres.sv
module wdog_mulres #(
  parameter int MULT_W    = 5,
  parameter int RES_W     = 2,
  parameter int RES_SHIFT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic                          reg_acc,
  input  logic                          reg_wr,
  input  logic [MULT_W+RES_W:0]         reg_wdata,
  input  logic                          flag_rd,
  output logic [MULT_W+RES_W:0]         ctl_q,
  output logic                          wd_flag,
  output logic                          irq
);
  localparam int REG_W  = 1 + MULT_W + RES_W;
  localparam int MAX_SH = RES_SHIFT * ((1 << RES_W) - 1);
  localparam int CNT_W  = MULT_W + MAX_SH;

  logic [CNT_W-1:0] cnt_q;

  wire [MULT_W-1:0] mult  = ctl_q[REG_W-2:RES_W];
  wire [RES_W-1:0]  res   = ctl_q[RES_W-1:0];
  wire              steer = ctl_q[REG_W-1];
  wire              armed = |mult;
  wire [CNT_W-1:0]  limit = CNT_W'(mult) << (res * RES_SHIFT);
  wire              expire = tick && armed && !reg_acc && (cnt_q == limit - 1'b1);
  wire              clr    = reg_acc || flag_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cnt_q   <= '0;
      wd_flag <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (reg_acc && reg_wr) ctl_q <= reg_wdata;

      if (reg_acc || !armed) cnt_q <= '0;
      else if (tick)         cnt_q <= expire ? '0 : cnt_q + 1'b1;

      if (expire) begin
        wd_flag <= 1'b1;
        irq     <= irq | ~steer;
      end else if (clr) begin
        wd_flag <= 1'b0;
        irq     <= 1'b0;
      end
    end
  end

  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wd_flag);

  a_r4_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reg_acc |=> (!wd_flag && !irq));

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mult == '0 && !reg_acc) |=> !$rose(wd_flag));

  a_r6_steer_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    steer |=> !$rose(irq));

  a_r3_rise_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !$rose(wd_flag));

  a_r2_read_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_acc && reg_wr) |=> $stable(ctl_q));
endmodule

// File: tb/wdog_mulres_tb.sv
module wdog_mulres_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, reg_acc = 1'b0, reg_wr = 1'b0, flag_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] ctl_q;
  logic wd_flag, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wdog_mulres dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_acc(reg_acc), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .flag_rd(flag_rd), .ctl_q(ctl_q), .wd_flag(wd_flag), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic a, input logic w,
                      input logic [7:0] d, input logic f);
    @(negedge clk);
    tick = t; reg_acc = a; reg_wr = w; reg_wdata = d; flag_rd = f;
    @(negedge clk);
    tick = 0; reg_acc = 0; reg_wr = 0; flag_rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 8'h00, 0);
  endtask

  task automatic wr(input logic [7:0] d);
    step(0, 1, 1, d, 0);
  endtask

  task automatic run_case(input int m, input int c, input logic s);
    int n;
    n = m * (1 << (2 * c));
    wr({s, m[4:0], c[1:0]});
    chk("R2 write", ctl_q, {s, m[4:0], c[1:0]});
    ticks(n - 1);
    chk("R3 early flag", wd_flag, 0);
    ticks(1);
    chk("R3 flag at timeout", wd_flag, 1);
    chk(s ? "R6 steer irq" : "R5 irq", irq, s ? 0 : 1);
    step(0, 0, 0, 8'h00, 1);
    chk("R7 flag clr", wd_flag, 0);
    chk("R7 irq clr", irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reg", ctl_q, 0);
    chk("R1 flag", wd_flag, 0);
    chk("R1 irq", irq, 0);

    ticks(300);
    chk("R8 disabled at reset", wd_flag, 0);
    wr(8'b0000_0011);
    ticks(300);
    chk("R8 zero mult res3", wd_flag, 0);
    wr(8'b1000_0001);
    ticks(50);
    chk("R8 zero mult steer", wd_flag, 0);

    for (int m = 1; m < 32; m++) run_case(m, 0, m[0]);
    for (int m = 1; m < 32; m++) run_case(m, 1, ~m[0]);
    run_case(1, 2, 0); run_case(5, 2, 1); run_case(31, 2, 0);
    run_case(1, 3, 1); run_case(2, 3, 0); run_case(3, 3, 0);

    // R2 read access leaves the register unchanged
    wr(8'b0001_0001);
    step(0, 1, 0, 8'hFF, 0);
    chk("R2 read no change", ctl_q, 8'b0001_0001);

    // R4 read access restarts the count (M=4, C=1 -> 16 ticks)
    ticks(12);
    step(0, 1, 0, 8'h00, 0);
    ticks(15);
    chk("R4 restart early", wd_flag, 0);
    ticks(1);
    chk("R4 restart timeout", wd_flag, 1);

    // R7 register access clears flag and irq
    chk("R7 irq before", irq, 1);
    step(0, 1, 0, 8'h00, 0);
    chk("R7 access clr flag", wd_flag, 0);
    chk("R7 access clr irq", irq, 0);

    // R9 periodic re-expiry and expiry beats flag read
    wr(8'b0000_1100);
    ticks(3);
    chk("R9 first expiry", wd_flag, 1);
    step(0, 0, 0, 8'h00, 1);
    ticks(2);
    chk("R9 second early", wd_flag, 0);
    step(1, 0, 0, 8'h00, 1);
    chk("R9 expiry over flag read", wd_flag, 1);

    // R10 tick coincident with access is ignored
    wr(8'b0001_0000);
    ticks(3);
    step(1, 1, 0, 8'h00, 0);
    chk("R10 no expiry on access tick", wd_flag, 0);
    ticks(3);
    chk("R10 restart early", wd_flag, 0);
    ticks(1);
    chk("R10 restart timeout", wd_flag, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule